// File: doc/BRIEF.md
# Digital Output Voltage Servo Controller

This block fine-tunes the reference DAC code of a voltage regulator. The goal is for the measured output voltage to settle on the commanded target. It does not run a continuous control loop. It decides slowly whether a correction is allowed and then moves the DAC code by a single LSB once per long, fixed period. It moves up when the ADC reading is below the target, moves down when it is above, and leaves the code alone when the two are equal. The DAC code saturates at both ends and never wraps.

The servo runs only when all of the following hold:
- its mode bit is set;
- the output rise sequence has finished;
- no undervoltage fault is present;
- no overcurrent fault is present;
- the load-line (voltage positioning) percentage is zero.

Once these conditions hold, an engagement delay counted in reference ticks must pass. A programmed delay of zero means there is no wait. When any condition drops, the servo disengages at once and holds the code, and the delay and the step period both start again from zero. With the mode bit cleared, the DAC code simply follows the target code.

The FSM has three states:
- IDLE: the controller is waiting for conditions.
- ARMING: the engagement delay is running.
- ENGAGED: stepping is enabled.

Its transitions are:
- IDLE to ENGAGED when the conditions hold and the delay is zero.
- IDLE to ARMING when the conditions hold and the delay is nonzero.
- ARMING to ENGAGED when the delay expires, or when the delay is reprogrammed to zero.
- ARMING to IDLE, and ENGAGED to IDLE, when any condition drops.

The step period is a prescaler of PERIOD_TICKS reference ticks. At the default of 90, with a 1 ms tick, this gives a 90 ms step. One range bit selects the DAC LSB size: either a coarse 1.375 mV or a fine 0.6875 mV. The ADC reading is always counted in 0.6875 mV units.

Top module: `vout_servo_ctrl`

## Requirements
- R1: While reset is asserted, `dac_code` is 0 and the servo is not engaged.
- R2: While `cfg_servo_en` is 0, `dac_code` takes the value of `target_code` at every clock edge.
- R3: While `rise_done` is 0, no step is taken and `dac_code` holds.
- R4: While `uv_fault` or `oc_fault` is 1, no step is taken and `dac_code` holds.
- R5: While `avp_pct` is nonzero, no step is taken and `dac_code` holds.
- R6: Once all enable conditions hold, the servo engages after `engage_delay` reference ticks. If `engage_delay` is 0, it engages at the next clock edge.
- R7: While engaged, `dac_code` changes by exactly one LSB at the end of every PERIOD_TICKS reference ticks. The first step comes PERIOD_TICKS ticks after engagement. Clock cycles without `ref_tick` do not advance the period.
- R8: The step direction is +1 when the ADC reading is below the scaled target and -1 when it is above. No step is taken when they are equal.
- R9: With `range_fine`=1, the ADC reading is compared with `target_code`. With `range_fine`=0 (coarse range, where one DAC LSB equals two ADC counts), it is compared with `target_code`*2.
- R10: `dac_code` saturates: a step up at the maximum code and a step down at 0 leave the code unchanged.
- R11: When any enable condition drops, `dac_code` holds from that cycle onward. Once the conditions hold again, both the engagement delay and the step period restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference tick used by the delay and the prescaler |
| cfg_servo_en | input | 1 | Servo mode enable |
| rise_done | input | 1 | Output rise sequence finished |
| uv_fault | input | 1 | Output undervoltage fault present |
| oc_fault | input | 1 | Output overcurrent fault present |
| avp_pct | input | AVP_W | Load-line percentage; the servo needs 0 |
| engage_delay | input | LIM_W | Engagement delay in reference ticks; 0 means none |
| adc_code | input | DAC_W+1 | Measured output voltage in fine ADC counts |
| target_code | input | DAC_W | Commanded voltage in DAC codes |
| range_fine | input | 1 | 1 = fine DAC LSB, 0 = coarse DAC LSB |
| dac_code | output | DAC_W | Trimmed reference DAC code |

## Verification
The checker assumes that `target_code` is stable during any cycle in which the mode bit is low and the DAC is loading it. It also assumes that `ref_tick` is a single-cycle level that is sampled at the clock edge. The step-size and direction properties rely on `adc_code` and `range_fine` staying constant across the edge at which a step lands. The stimulus follows these assumptions: it changes every input only on the falling clock edge, it loads the DAC through the mode-off path before each case, and it holds the ADC reading constant while the servo runs open loop.

// File: rtl/servo_pkg.sv
package servo_pkg;

    typedef enum logic [1:0] {
        SV_IDLE    = 2'd0,
        SV_ARMING  = 2'd1,
        SV_ENGAGED = 2'd2
    } servo_state_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/servo_gate.sv
module servo_gate #(
    parameter int AVP_W = 8
) (
    input  logic             cfg_servo_en,
    input  logic             rise_done,
    input  logic             uv_fault,
    input  logic             oc_fault,
    input  logic [AVP_W-1:0] avp_pct,
    output logic             cond_ok
);

    logic faults_clear;
    logic avp_zero;

    always_comb begin
        faults_clear = !uv_fault && !oc_fault;
        avp_zero     = (avp_pct == '0);
        cond_ok      = cfg_servo_en && rise_done && faults_clear && avp_zero;
    end

endmodule

// File: rtl/servo_tick_counter.sv
module servo_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // done fires on the tick that completes 'limit' ticks of running
    always_comb begin
        done = run && tick && (limit != '0) && (cnt_q == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/servo_compare.sv
module servo_compare
    import servo_pkg::*;
#(
    parameter int DAC_W = 12
) (
    input  logic [DAC_W:0]   adc_code,
    input  logic [DAC_W-1:0] target_code,
    input  logic             range_fine,
    output step_dir_e        dir
);

    logic [DAC_W:0] target_scaled;

    always_comb begin
        // coarse DAC LSB spans two ADC counts
        target_scaled = range_fine ? {1'b0, target_code} : {target_code, 1'b0};
        if (adc_code < target_scaled) begin
            dir = DIR_UP;
        end else if (adc_code > target_scaled) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
    end

endmodule

// File: rtl/servo_dac_reg.sv
module servo_dac_reg
    import servo_pkg::*;
#(
    parameter int DAC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             follow,
    input  logic [DAC_W-1:0] load_val,
    input  logic             step_en,
    input  step_dir_e        dir,
    output logic [DAC_W-1:0] dac_code
);

    localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};
    localparam logic [DAC_W-1:0] CODE_MIN = '0;

    logic [DAC_W-1:0] dac_q;
    logic [DAC_W-1:0] dac_d;

    always_comb begin
        dac_d = dac_q;
        if (follow) begin
            dac_d = load_val;
        end else if (step_en) begin
            unique case (dir)
                DIR_UP:   if (dac_q != CODE_MAX) dac_d = dac_q + 1'b1;
                DIR_DOWN: if (dac_q != CODE_MIN) dac_d = dac_q - 1'b1;
                default:  dac_d = dac_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= CODE_MIN;
        end else begin
            dac_q <= dac_d;
        end
    end

    assign dac_code = dac_q;

endmodule

// File: rtl/vout_servo_ctrl.sv
module vout_servo_ctrl
    import servo_pkg::*;
#(
    parameter int DAC_W        = 12,
    parameter int AVP_W        = 8,
    parameter int LIM_W        = 16,
    parameter int PERIOD_TICKS = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             cfg_servo_en,
    input  logic             rise_done,
    input  logic             uv_fault,
    input  logic             oc_fault,
    input  logic [AVP_W-1:0] avp_pct,
    input  logic [LIM_W-1:0] engage_delay,
    input  logic [DAC_W:0]   adc_code,
    input  logic [DAC_W-1:0] target_code,
    input  logic             range_fine,
    output logic [DAC_W-1:0] dac_code
);

    localparam int               PER_W     = $clog2(PERIOD_TICKS + 1);
    localparam logic [PER_W-1:0] PER_LIMIT = PER_W'(PERIOD_TICKS);

    servo_state_e state_q;
    servo_state_e state_d;

    logic      cond_ok;
    logic      delay_zero;
    logic      delay_done;
    logic      period_done;
    logic      engaged;
    logic      arming;
    logic      step_en;
    step_dir_e dir;

    servo_gate #(.AVP_W(AVP_W)) u_gate (
        .cfg_servo_en (cfg_servo_en),
        .rise_done    (rise_done),
        .uv_fault     (uv_fault),
        .oc_fault     (oc_fault),
        .avp_pct      (avp_pct),
        .cond_ok      (cond_ok)
    );

    assign delay_zero = (engage_delay == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_IDLE: begin
                if (cond_ok) state_d = delay_zero ? SV_ENGAGED : SV_ARMING;
            end
            SV_ARMING: begin
                if (!cond_ok)                     state_d = SV_IDLE;
                else if (delay_zero || delay_done) state_d = SV_ENGAGED;
            end
            SV_ENGAGED: begin
                if (!cond_ok) state_d = SV_IDLE;
            end
            default: state_d = SV_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // state-decoded outputs
    always_comb begin
        engaged = (state_q == SV_ENGAGED);
        arming  = (state_q == SV_ARMING);
        step_en = period_done && cond_ok;
    end

    servo_tick_counter #(.CNT_W(LIM_W)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (arming),
        .tick  (ref_tick),
        .limit (engage_delay),
        .done  (delay_done)
    );

    servo_tick_counter #(.CNT_W(PER_W)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (engaged),
        .tick  (ref_tick),
        .limit (PER_LIMIT),
        .done  (period_done)
    );

    servo_compare #(.DAC_W(DAC_W)) u_cmp (
        .adc_code    (adc_code),
        .target_code (target_code),
        .range_fine  (range_fine),
        .dir         (dir)
    );

    servo_dac_reg #(.DAC_W(DAC_W)) u_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .follow   (!cfg_servo_en),
        .load_val (target_code),
        .step_en  (step_en),
        .dir      (dir),
        .dac_code (dac_code)
    );

endmodule

// File: rtl/servo_chk.sv
module servo_chk #(
    parameter int DAC_W = 12,
    parameter int AVP_W = 8,
    parameter int LIM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             cfg_servo_en,
    input logic             rise_done,
    input logic             uv_fault,
    input logic             oc_fault,
    input logic [AVP_W-1:0] avp_pct,
    input logic [LIM_W-1:0] engage_delay,
    input logic [DAC_W:0]   adc_code,
    input logic [DAC_W-1:0] target_code,
    input logic             range_fine,
    input logic [DAC_W-1:0] dac_code,
    input logic             engaged
);

    logic [DAC_W:0] ref_scaled;
    logic           all_ok;

    assign ref_scaled = range_fine ? {1'b0, target_code} : {target_code, 1'b0};
    assign all_ok     = cfg_servo_en && rise_done && !uv_fault && !oc_fault && (avp_pct == '0);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (!engaged);
        end
    end

    // R2
    mode_off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_servo_en |=> dac_code == $past(target_code));

    // R3
    rise_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && !rise_done |=> $stable(dac_code) && !engaged);

    // R4
    fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && (uv_fault || oc_fault) |=> $stable(dac_code) && !engaged);

    // R5
    avp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && (avp_pct != '0) |=> $stable(dac_code) && !engaged);

    // R6
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_ok && (engage_delay == '0) |=> engaged);

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && !ref_tick |=> $stable(dac_code));

    // R10
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && engaged |=>
            ({1'b0, dac_code} == {1'b0, $past(dac_code)}) ||
            ({1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1) ||
            ({1'b0, dac_code} + 1'b1 == {1'b0, $past(dac_code)}));

    // R8
    dir_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && engaged && (adc_code < ref_scaled) |=> dac_code >= $past(dac_code));

    // R8
    dir_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && engaged && (adc_code > ref_scaled) |=> dac_code <= $past(dac_code));

    // R9
    equal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && (adc_code == ref_scaled) |=> $stable(dac_code));

    // R11
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_servo_en && !all_ok |=> $stable(dac_code) && !engaged);

endmodule

bind vout_servo_ctrl servo_chk #(
    .DAC_W (DAC_W),
    .AVP_W (AVP_W),
    .LIM_W (LIM_W)
) u_servo_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .cfg_servo_en (cfg_servo_en),
    .rise_done    (rise_done),
    .uv_fault     (uv_fault),
    .oc_fault     (oc_fault),
    .avp_pct      (avp_pct),
    .engage_delay (engage_delay),
    .adc_code     (adc_code),
    .target_code  (target_code),
    .range_fine   (range_fine),
    .dac_code     (dac_code),
    .engaged      (engaged)
);

// File: tb/vout_servo_ctrl_bench.sv
module vout_servo_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DAC_W      = 8;
    localparam int AVP_W      = 8;
    localparam int LIM_W      = 8;
    localparam int PER        = 4;

    typedef struct packed {
        logic [DAC_W:0]   adc;
        logic [DAC_W-1:0] tgt;
        logic             fine;
        logic [DAC_W-1:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{adc: 9'd99,  tgt: 8'd100, fine: 1'b1, exp: 8'd101},
        '{adc: 9'd101, tgt: 8'd100, fine: 1'b1, exp: 8'd99},
        '{adc: 9'd100, tgt: 8'd100, fine: 1'b1, exp: 8'd100},
        '{adc: 9'd200, tgt: 8'd100, fine: 1'b0, exp: 8'd100},
        '{adc: 9'd199, tgt: 8'd100, fine: 1'b0, exp: 8'd101},
        '{adc: 9'd201, tgt: 8'd100, fine: 1'b0, exp: 8'd99},
        '{adc: 9'd100, tgt: 8'd100, fine: 1'b0, exp: 8'd101},
        '{adc: 9'd0,   tgt: 8'd255, fine: 1'b1, exp: 8'd255},
        '{adc: 9'd300, tgt: 8'd0,   fine: 1'b1, exp: 8'd0},
        '{adc: 9'd510, tgt: 8'd255, fine: 1'b0, exp: 8'd255},
        '{adc: 9'd509, tgt: 8'd255, fine: 1'b0, exp: 8'd255}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ref_tick;
    logic             cfg_servo_en;
    logic             rise_done;
    logic             uv_fault;
    logic             oc_fault;
    logic [AVP_W-1:0] avp_pct;
    logic [LIM_W-1:0] engage_delay;
    logic [DAC_W:0]   adc_code;
    logic [DAC_W-1:0] target_code;
    logic             range_fine;
    logic [DAC_W-1:0] dac_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vout_servo_ctrl #(
        .DAC_W        (DAC_W),
        .AVP_W        (AVP_W),
        .LIM_W        (LIM_W),
        .PERIOD_TICKS (PER)
    ) u_vout_servo_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .cfg_servo_en (cfg_servo_en),
        .rise_done    (rise_done),
        .uv_fault     (uv_fault),
        .oc_fault     (oc_fault),
        .avp_pct      (avp_pct),
        .engage_delay (engage_delay),
        .adc_code     (adc_code),
        .target_code  (target_code),
        .range_fine   (range_fine),
        .dac_code     (dac_code)
    );

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DAC_W-1:0] exp);
        n_checks++;
        if (dac_code !== exp) begin
            n_fail++;
            $display("FAIL %s: dac_code=%0d expected %0d", req, dac_code, exp);
        end
    endtask

    // load the DAC through the mode-off path, then leave conditions healthy
    task automatic preload(input logic [DAC_W-1:0] val);
        cfg_servo_en = 1'b0;
        rise_done    = 1'b1;
        uv_fault     = 1'b0;
        oc_fault     = 1'b0;
        avp_pct      = '0;
        engage_delay = '0;
        ref_tick     = 1'b1;
        target_code  = val;
        edges(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        ref_tick     = 1'b1;
        cfg_servo_en = 1'b0;
        rise_done    = 1'b1;
        uv_fault     = 1'b0;
        oc_fault     = 1'b0;
        avp_pct      = '0;
        engage_delay = '0;
        adc_code     = '0;
        target_code  = 8'd77;
        range_fine   = 1'b1;
        edges(3);
        check("R1 reset value", 8'd0);
        rst_n = 1'b1;
        edges(1);
        check("R2 follow target", 8'd77);
        target_code = 8'd33;
        edges(1);
        check("R2 follow new target", 8'd33);

        // vector table: one period of open-loop servo per entry
        for (int i = 0; i < NVEC; i++) begin
            preload(VECS[i].tgt);
            check("R2 preload", VECS[i].tgt);
            adc_code     = VECS[i].adc;
            range_fine   = VECS[i].fine;
            cfg_servo_en = 1'b1;
            edges(PER);
            check("R7 no step before period", VECS[i].tgt);
            edges(1);
            if (i < 3)      check("R8 direction", VECS[i].exp);
            else if (i < 7) check("R9 range scaling", VECS[i].exp);
            else            check("R10 saturation", VECS[i].exp);
        end

        // R3: rise sequence not finished
        preload(8'd50);
        adc_code = 9'd0; range_fine = 1'b1;
        rise_done = 1'b0; cfg_servo_en = 1'b1;
        edges(20);
        check("R3 hold before rise done", 8'd50);
        rise_done = 1'b1;
        edges(PER + 1);
        check("R3 step after rise done", 8'd51);

        // R4: undervoltage and overcurrent faults
        preload(8'd50);
        uv_fault = 1'b1; cfg_servo_en = 1'b1;
        edges(20);
        check("R4 hold on uv fault", 8'd50);
        uv_fault = 1'b0; oc_fault = 1'b1;
        edges(20);
        check("R4 hold on oc fault", 8'd50);

        // R5: nonzero positioning percentage
        preload(8'd50);
        avp_pct = 8'd5; cfg_servo_en = 1'b1;
        edges(20);
        check("R5 hold with nonzero avp", 8'd50);

        // R6: delay of 3 ticks then period of PER
        preload(8'd50);
        engage_delay = 8'd3; cfg_servo_en = 1'b1;
        edges(1 + 3 + PER - 1);
        check("R6 no step during delay", 8'd50);
        edges(1);
        check("R6 step after delay", 8'd51);

        // R7: period advances only on ref ticks
        preload(8'd50);
        ref_tick = 1'b0; cfg_servo_en = 1'b1;
        edges(30);
        check("R7 no tick no step", 8'd50);
        ref_tick = 1'b1;
        edges(PER - 1);
        check("R7 partial period", 8'd50);
        edges(1);
        check("R7 first step", 8'd51);
        edges(PER);
        check("R7 second step", 8'd52);

        // R11: drop condition mid-period, hold, restart
        preload(8'd50);
        cfg_servo_en = 1'b1;
        edges(PER + 1);
        check("R11 first step", 8'd51);
        edges(2);
        uv_fault = 1'b1;
        edges(10);
        check("R11 hold while dropped", 8'd51);
        uv_fault = 1'b0;
        edges(PER);
        check("R11 period restarted", 8'd51);
        edges(1);
        check("R11 step after restart", 8'd52);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule